// File: doc/BRIEF.md
# SPI Master Controller with Word FIFOs and Burst Framing

This block is the master side of a four-wire serial peripheral link. Software-style control inputs set the word length, the serial clock rate, the clock polarity and phase, the chip-select line to drive, and the framing behaviour. Words are queued in a transmit FIFO. Each shifted word produces one received word, which is queued in a receive FIFO. The head of that FIFO is always visible on the read port.

Serial clock timing comes from a two-stage divider made of a prescaler and a rate divider. An optional burst mode keeps the selected chip select low across consecutive words until a word tagged with a stop marker completes. A pause control stops new words from starting, so a burst can be queued in full before any of it goes out. An internal loopback feeds the outgoing data line back into the receiver. A slave-output-disable control suppresses every chip-select line, for systems that decode selects elsewhere.

Top module: `spim_master`

## Requirements
- R1: The transmit FIFO holds 16 words. `st_tx_not_full` is low when it holds 16 words, and a push while it is full is discarded: it causes no later transfer.
- R2: After reset, `st_tx_empty`=1, `st_tx_not_full`=1, `st_rx_not_empty`=0 and `st_rx_overrun`=0, and every `cs_n` line is high. `st_tx_empty` and `st_rx_not_empty` follow the FIFO contents.
- R3: `cfg_bits_m1` holds the word length minus one (3 gives 4 bits, 7 gives 8 bits, 15 gives 16 bits). Only the low word-length bits of `tx_word` are sent, most significant first. Received words are zero above the word length.
- R4: The serial clock period, in clock cycles, is P*(`cfg_rate_div`+1), where P is `cfg_prescale` rounded down to an even value (minimum 2). For example, prescale 4 with divider 2 gives 12 cycles, and prescale 5 with divider 1 gives 8.
- R5: Modes follow (`cfg_cpol`,`cfg_cpha`). SCK idles at `cfg_cpol`. With phase 0, data is valid on the leading (first) edge of each bit. With phase 1, data is valid on the trailing edge.
- R6: While a word is in flight, exactly the line `cs_n[cfg_cs_sel]` is low. With `cfg_cs_off`=1, all `cs_n` lines stay high. At most one line is low at any time.
- R7: With `cfg_block`=1, chip select stays low from the first word until a word pushed with `tx_stop`=1 has completed. The frame stays open while the FIFO is empty. With `cfg_block`=0, every word is a frame of its own.
- R8: While `cfg_pause`=1, no new word starts, and SCK does not toggle while the block is idle. Clearing it sends the queued words.
- R9: With `cfg_loop`=1, the received bits are the transmitted bits. With `cfg_loop`=0, they come from `miso`.
- R10: Each completed word pushes exactly one word into the 16-deep receive FIFO. A word that arrives when that FIFO is full is dropped, the older contents are kept, and `st_rx_overrun` sets and stays set.
- R11: A one-cycle `tx_clear` empties the transmit FIFO. A one-cycle `rx_clear` empties the receive FIFO and clears `st_rx_overrun`.
- R12: With `cfg_enable`=0, no word is shifted, SCK sits at `cfg_cpol` from the next cycle, and queued words stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Enables shifting |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase |
| cfg_bits_m1 | input | 4 | Word length minus one |
| cfg_prescale | input | 8 | First divider stage |
| cfg_rate_div | input | 8 | Second divider stage, minus one |
| cfg_cs_sel | input | 3 | Chip-select line to drive |
| cfg_cs_off | input | 1 | Suppress all chip selects |
| cfg_block | input | 1 | Burst framing enable |
| cfg_pause | input | 1 | Hold off new words |
| cfg_loop | input | 1 | Internal loopback |
| tx_push | input | 1 | Queue `tx_word` |
| tx_word | input | 16 | Word to send |
| tx_stop | input | 1 | Marks the last word of a burst |
| tx_clear | input | 1 | Empty the transmit FIFO |
| rx_pop | input | 1 | Drop the receive head |
| rx_clear | input | 1 | Empty the receive FIFO and clear overrun |
| rx_word | output | 16 | Receive FIFO head |
| st_tx_not_full | output | 1 | Transmit FIFO has space |
| st_tx_empty | output | 1 | Transmit FIFO is empty |
| st_rx_not_empty | output | 1 | Receive FIFO holds data |
| st_rx_overrun | output | 1 | Sticky received-word loss |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The assertions assume that the mode, word length, divider and select inputs change only while no word is in flight. They also assume that every strobe lasts a single cycle. The pause property further assumes that the polarity input holds steady across the cycles it compares. The stimulus meets all of this by reconfiguring only after it has waited for an empty transmit FIFO and released chip selects. It also drives every strobe for exactly one cycle.

// File: rtl/spim_pkg.sv
// Shared definitions for the SPI master: sequencer states.
package spim_pkg;
    // Sequencer phases of one word and of a held burst frame.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // no frame open
        ST_LEAD = 3'd1,   // select asserted, first half period before edges
        ST_XFER = 3'd2,   // clock edges running
        ST_TAIL = 3'd3,   // half period after the last edge
        ST_HOLD = 3'd4    // burst frame open, waiting for more words
    } spim_state_t;
endpackage

// File: rtl/spim_fifo.sv
// Synchronous first-in first-out store with show-ahead read.
// Assumes: push on full and pop on empty are ignored here; clear wins over both.
module spim_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/spim_clkdiv.sv
// Two-stage divider producing one-cycle half-period ticks for the serial clock.
// Assumes: half period = (prescale/2, minimum 1) * (rate_div + 1) cycles.
module spim_clkdiv #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    input  logic [DIV_W-1:0] rate_div,
    output logic             tick
);
    logic [PRE_W-1:0] half, cnt1;
    logic [DIV_W-1:0] cnt2;
    logic             wrap1;

    // Effective first-stage length, never zero.
    always_comb begin
        half = prescale >> 1;
        if (half == '0) half = PRE_W'(1);
    end

    assign wrap1 = (cnt1 >= half - 1'b1);
    assign tick  = run && wrap1 && (cnt2 >= rate_div);

    // Cascaded counters; both restart whenever shifting is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt1 <= '0;
            cnt2 <= '0;
        end else if (wrap1) begin
            cnt1 <= '0;
            cnt2 <= (cnt2 >= rate_div) ? '0 : cnt2 + 1'b1;
        end else begin
            cnt1 <= cnt1 + 1'b1;
        end
    end
endmodule

// File: rtl/spim_engine.sv
// Word sequencer and shift registers: frames words, generates clock edges,
// shifts data out MSB first and assembles the received word.
// Assumes: mode and word-length inputs are stable while a word is in flight.
module spim_engine
    import spim_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              cpha,
    input  logic [LEN_W-1:0]  bits_m1,
    input  logic              block,
    input  logic              pause,
    input  logic              loopback,
    input  logic              tx_avail,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_stop,
    output logic              tx_take,
    input  logic              miso,
    output logic              rx_put,
    output logic [DATA_W-1:0] rx_word,
    output logic              lvl,
    output logic              mosi,
    output logic              cs_act
);
    localparam int EDGE_W = LEN_W + 1;

    spim_state_t       state;
    logic [DATA_W-1:0] sr, rx_sr, mask;
    logic [EDGE_W-1:0] edge_q, last_edge;
    logic [LEN_W-1:0]  wbits_q, sh;
    logic [LEN_W:0]    wlen;
    logic              stop_q, lvl_q, cs_q;
    logic              leading, sample_now, shift_now, rx_bit, may_start;
    logic [DATA_W-1:0] one_v;

    assign one_v      = DATA_W'(1);
    assign mosi       = sr[DATA_W-1];
    assign lvl        = lvl_q;
    assign cs_act     = cs_q;
    assign rx_bit     = loopback ? mosi : miso;
    assign last_edge  = {wbits_q, 1'b1};
    assign leading    = !edge_q[0];
    assign sample_now = cpha ? !leading : leading;
    assign shift_now  = cpha ? (leading && edge_q != '0) : !leading;
    assign wlen       = {1'b0, wbits_q} + 1'b1;
    assign mask       = (one_v << wlen) - one_v;
    assign rx_word    = rx_sr & mask;
    assign sh         = LEN_W'(DATA_W - 1) - bits_m1;

    // Start of the next word: fresh frame from idle, or continuation of a burst.
    always_comb begin
        may_start = 1'b0;
        case (state)
            ST_IDLE: may_start = 1'b1;
            ST_HOLD: may_start = block;
            ST_TAIL: may_start = block && !stop_q;
            default: may_start = 1'b0;
        endcase
    end
    assign tx_take = run && tick && tx_avail && !pause && may_start;
    assign rx_put  = run && tick && (state == ST_TAIL);

    // Sequencer, clock level, and data shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state   <= ST_IDLE;
            sr      <= '0;
            rx_sr   <= '0;
            edge_q  <= '0;
            wbits_q <= '0;
            stop_q  <= 1'b0;
            lvl_q   <= 1'b0;
            cs_q    <= 1'b0;
        end else if (tx_take) begin
            sr      <= tx_word << sh;
            wbits_q <= bits_m1;
            stop_q  <= tx_stop;
            edge_q  <= '0;
            cs_q    <= 1'b1;
            state   <= ST_LEAD;
        end else if (tick) begin
            case (state)
                ST_LEAD: begin
                    edge_q <= '0;
                    state  <= ST_XFER;
                end
                ST_XFER: begin
                    lvl_q <= ~lvl_q;
                    if (sample_now) rx_sr <= {rx_sr[DATA_W-2:0], rx_bit};
                    if (shift_now)  sr    <= sr << 1;
                    if (edge_q == last_edge) state <= ST_TAIL;
                    else                     edge_q <= edge_q + 1'b1;
                end
                ST_TAIL: begin
                    if (block && !stop_q) begin
                        state <= ST_HOLD;
                    end else begin
                        cs_q  <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                ST_HOLD: begin
                    if (!block) begin
                        cs_q  <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spim_master.sv
// SPI master top: transmit and receive FIFOs, clock divider, word engine,
// chip-select decode, status and overrun tracking.
// Assumes: configuration inputs change only while no word is in flight.
module spim_master #(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_CS     = 8,
    parameter int PRE_W      = 8,
    parameter int DIV_W      = 8,
    localparam int LEN_W     = $clog2(DATA_W),
    localparam int CS_W      = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [LEN_W-1:0]  cfg_bits_m1,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [DIV_W-1:0]  cfg_rate_div,
    input  logic [CS_W-1:0]   cfg_cs_sel,
    input  logic              cfg_cs_off,
    input  logic              cfg_block,
    input  logic              cfg_pause,
    input  logic              cfg_loop,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_stop,
    input  logic              tx_clear,
    input  logic              rx_pop,
    input  logic              rx_clear,
    output logic [DATA_W-1:0] rx_word,
    output logic              st_tx_not_full,
    output logic              st_tx_empty,
    output logic              st_rx_not_empty,
    output logic              st_rx_overrun,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    logic [DATA_W:0]   txf_rdata;
    logic              txf_empty, txf_full, rxf_empty, rxf_full;
    logic              tick, tx_take, rx_put, lvl, cs_act;
    logic [DATA_W-1:0] eng_rx_word;
    logic              ovr_q;

    spim_fifo #(.DW(DATA_W + 1), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(tx_clear),
        .push(tx_push), .wdata({tx_stop, tx_word}),
        .pop(tx_take), .rdata(txf_rdata),
        .empty(txf_empty), .full(txf_full)
    );

    spim_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_clear),
        .push(rx_put), .wdata(eng_rx_word),
        .pop(rx_pop), .rdata(rx_word),
        .empty(rxf_empty), .full(rxf_full)
    );

    spim_clkdiv #(.PRE_W(PRE_W), .DIV_W(DIV_W)) clkdiv_i (
        .clk(clk), .rst_n(rst_n), .run(cfg_enable),
        .prescale(cfg_prescale), .rate_div(cfg_rate_div), .tick(tick)
    );

    spim_engine #(.DATA_W(DATA_W)) engine_i (
        .clk(clk), .rst_n(rst_n), .run(cfg_enable), .tick(tick),
        .cpha(cfg_cpha), .bits_m1(cfg_bits_m1), .block(cfg_block),
        .pause(cfg_pause), .loopback(cfg_loop),
        .tx_avail(!txf_empty), .tx_word(txf_rdata[DATA_W-1:0]),
        .tx_stop(txf_rdata[DATA_W]), .tx_take(tx_take),
        .miso(miso), .rx_put(rx_put), .rx_word(eng_rx_word),
        .lvl(lvl), .mosi(mosi), .cs_act(cs_act)
    );

    // Sticky loss flag for words arriving at a full receive FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clear) ovr_q <= 1'b0;
        else if (rx_put && rxf_full) ovr_q <= 1'b1;
    end

    // One decoded active-low select per line.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(cs_act && !cfg_cs_off && (cfg_cs_sel == CS_W'(g)));
    end

    assign sck             = cfg_cpol ^ lvl;
    assign st_tx_not_full  = !txf_full;
    assign st_tx_empty     = txf_empty;
    assign st_rx_not_empty = !rxf_empty;
    assign st_rx_overrun   = ovr_q;
endmodule

// File: rtl/spim_master_chk.sv
// Property checker for spim_master, attached with bind.
// Assumes: strobes are one cycle wide, configuration changes only between words.
module spim_master_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              cfg_cpol,
    input logic              cfg_cs_off,
    input logic              cfg_pause,
    input logic              tx_clear,
    input logic              rx_clear,
    input logic              st_tx_not_full,
    input logic              st_tx_empty,
    input logic              st_rx_not_empty,
    input logic              st_rx_overrun,
    input logic              sck,
    input logic [NUM_CS-1:0] cs_n
);
    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_tx_not_full && !cfg_enable && !tx_clear) |=> !st_tx_not_full);

    p_empty_not_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_tx_empty |-> st_tx_not_full);

    p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_cs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cs_off |-> (&cs_n));

    p_pause_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pause && $past(cfg_pause) && !cfg_cs_off && !$past(cfg_cs_off)
         && (&cs_n) && $past(&cs_n) && $stable(cfg_cpol)) |-> $stable(sck));

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rx_overrun && !rx_clear) |=> st_rx_overrun);

    p_tx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clear |=> st_tx_empty);

    p_rx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear |=> (!st_rx_not_empty && !st_rx_overrun));

    p_sck_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && $stable(cfg_cpol)) |=> (sck == cfg_cpol));
endmodule

bind spim_master spim_master_chk #(.NUM_CS(NUM_CS)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
    .cfg_cs_off(cfg_cs_off), .cfg_pause(cfg_pause),
    .tx_clear(tx_clear), .rx_clear(rx_clear),
    .st_tx_not_full(st_tx_not_full), .st_tx_empty(st_tx_empty),
    .st_rx_not_empty(st_rx_not_empty), .st_rx_overrun(st_rx_overrun),
    .sck(sck), .cs_n(cs_n)
);

// File: tb/spim_master_tb_top.sv
// Scoreboard bench: the driver queues expected serial and received words, the
// monitors compare them against the pins and the receive port.
module spim_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 0, cfg_cpol = 0, cfg_cpha = 0;
    logic [3:0]  cfg_bits_m1 = 4'd7;
    logic [7:0]  cfg_prescale = 8'd2, cfg_rate_div = 8'd0;
    logic [2:0]  cfg_cs_sel = 3'd0;
    logic        cfg_cs_off = 0, cfg_block = 0, cfg_pause = 0, cfg_loop = 1;
    logic        tx_push = 0, tx_stop = 0, tx_clear = 0, rx_pop = 0, rx_clear = 0;
    logic [15:0] tx_word = '0;
    logic [15:0] rx_word;
    logic        st_tx_not_full, st_tx_empty, st_rx_not_empty, st_rx_overrun;
    logic        sck, mosi, miso = 0;
    logic [7:0]  cs_n;

    always #2 clk = ~clk;   // 250 MHz

    spim_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_bits_m1(cfg_bits_m1), .cfg_prescale(cfg_prescale),
        .cfg_rate_div(cfg_rate_div), .cfg_cs_sel(cfg_cs_sel), .cfg_cs_off(cfg_cs_off),
        .cfg_block(cfg_block), .cfg_pause(cfg_pause), .cfg_loop(cfg_loop),
        .tx_push(tx_push), .tx_word(tx_word), .tx_stop(tx_stop), .tx_clear(tx_clear),
        .rx_pop(rx_pop), .rx_clear(rx_clear), .rx_word(rx_word),
        .st_tx_not_full(st_tx_not_full), .st_tx_empty(st_tx_empty),
        .st_rx_not_empty(st_rx_not_empty), .st_rx_overrun(st_rx_overrun),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    bit auto_drain = 1;
    logic [15:0] exp_tx[$];
    logic [15:0] exp_rx[$];
    int cyc = 0, edges = 0, frames = 0, words_seen = 0, rx_seen = 0;
    int last_period = 0, last_lead = 0, lead_idx = 0, bitcnt = 0;
    logic [15:0] bitbuf = '0;
    logic prev_sck = 0, prev_cpol = 0, lead;
    logic [7:0] prev_csn = 8'hFF;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_of(input logic [3:0] b);
        logic [16:0] one = 17'd1;
        return 16'((one << (b + 1)) - one);
    endfunction

    function automatic logic [7:0] exp_cs();
        return cfg_cs_off ? 8'hFF : ~(8'h01 << cfg_cs_sel);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Serial monitor: captures mosi at the mode's sampling edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck != prev_sck && cfg_cpol == prev_cpol) begin
                edges++;
                lead = (sck != cfg_cpol);
                if (lead) begin
                    if (lead_idx > 0) last_period = cyc - last_lead;
                    last_lead = cyc;
                    lead_idx++;
                end
                if (cfg_cpha ? !lead : lead) begin
                    bitbuf = {bitbuf[14:0], mosi};
                    bitcnt++;
                    chk(cs_n == exp_cs(), "R6", "select during bit", 32'(cs_n), 32'(exp_cs()));
                    if (bitcnt == int'(cfg_bits_m1) + 1) begin
                        words_seen++;
                        if (exp_tx.size() == 0)
                            chk(0, "R5", "unexpected serial word", 32'(bitbuf), 0);
                        else begin
                            logic [15:0] e;
                            e = exp_tx.pop_front();
                            chk((bitbuf & mask_of(cfg_bits_m1)) == e, "R5", "serial word",
                                32'(bitbuf & mask_of(cfg_bits_m1)), 32'(e));
                        end
                        bitcnt = 0; lead_idx = 0; bitbuf = '0;
                    end
                end
            end
            if ((&prev_csn) && !(&cs_n)) frames++;
            prev_sck = sck; prev_cpol = cfg_cpol; prev_csn = cs_n;
        end
    end

    // Receive monitor: pops and compares received words when draining is on.
    initial begin
        forever begin
            @(posedge clk); #1;
            rx_pop = 0;
            if (auto_drain && rst_n && st_rx_not_empty) begin
                rx_seen++;
                if (exp_rx.size() == 0)
                    chk(0, "R10", "unexpected received word", 32'(rx_word), 0);
                else begin
                    logic [15:0] e;
                    e = exp_rx.pop_front();
                    chk(rx_word == e, "R9", "received word", 32'(rx_word), 32'(e));
                end
                rx_pop = 1;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [15:0] w, input bit stop);
        @(posedge clk); #1;
        tx_push = 1; tx_word = w; tx_stop = stop;
        @(posedge clk); #1;
        tx_push = 0; tx_stop = 0;
    endtask

    // Driver: queues the expected serial and received words, then pushes.
    task automatic send(input logic [15:0] w, input bit stop);
        logic [15:0] m;
        m = w & mask_of(cfg_bits_m1);
        exp_tx.push_back(m);
        if (auto_drain) exp_rx.push_back(cfg_loop ? m : (miso ? mask_of(cfg_bits_m1) : 16'h0));
        push(w, stop);
    endtask

    task automatic wait_idle(input string req);
        int t;
        t = 0;
        while (!(st_tx_empty && (&cs_n) && exp_tx.size() == 0 &&
                 (!auto_drain || exp_rx.size() == 0)) && t < 20000) begin
            step(1); t++;
        end
        step(20);
        if (t >= 20000) chk(0, req, "drain timeout", 32'(exp_tx.size()), 0);
    endtask

    task automatic strobe_tx_clear();
        @(posedge clk); #1 tx_clear = 1;
        @(posedge clk); #1 tx_clear = 0;
    endtask

    task automatic strobe_rx_clear();
        @(posedge clk); #1 rx_clear = 1;
        @(posedge clk); #1 rx_clear = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int f0, e0, w0;
        step(5);
        rst_n = 1;
        step(2);
        // R2: reset state.
        chk(st_tx_empty == 1, "R2", "tx empty after reset", 32'(st_tx_empty), 1);
        chk(st_tx_not_full == 1, "R2", "tx not full after reset", 32'(st_tx_not_full), 1);
        chk(st_rx_not_empty == 0, "R2", "rx not empty after reset", 32'(st_rx_not_empty), 0);
        chk(st_rx_overrun == 0, "R2", "overrun after reset", 32'(st_rx_overrun), 0);
        chk(cs_n == 8'hFF, "R2", "selects after reset", 32'(cs_n), 32'hFF);

        // R12: disabled block idles at polarity and holds queued words.
        cfg_cpol = 1; step(2);
        chk(sck == 1, "R12", "sck idle high", 32'(sck), 1);
        e0 = edges;
        push(16'h00A5, 0);
        step(60);
        chk(edges == e0, "R12", "edges while disabled", 32'(edges), 32'(e0));
        chk(st_tx_empty == 0, "R12", "word kept while disabled", 32'(st_tx_empty), 0);
        chk(st_rx_not_empty == 0, "R2", "rx empty before transfer", 32'(st_rx_not_empty), 0);
        // R11: transmit clear.
        strobe_tx_clear();
        chk(st_tx_empty == 1, "R11", "tx empty after clear", 32'(st_tx_empty), 1);
        cfg_cpol = 0; step(2);
        cfg_enable = 1; step(2);

        // R5 and R3: every mode with several word lengths, loopback on.
        for (int m = 0; m < 4; m++) begin
            cfg_cpol = m[1]; cfg_cpha = m[0]; cfg_cs_sel = 3'(m * 2 + 1);
            cfg_bits_m1 = 4'd7;  step(4);
            send(16'h00C3, 0); send(16'h005A, 0);
            wait_idle("R5");
            cfg_bits_m1 = 4'd3;  step(4);
            send(16'hABCD, 0);
            wait_idle("R3");
            cfg_bits_m1 = 4'd15; step(4);
            send(16'h8E71, 0);
            wait_idle("R3");
        end
        cfg_cpol = 0; cfg_cpha = 0; cfg_bits_m1 = 4'd7; cfg_cs_sel = 3'd2; step(4);

        // R4: serial clock period.
        cfg_prescale = 8'd4; cfg_rate_div = 8'd2; step(4);
        send(16'h0033, 0); wait_idle("R4");
        chk(last_period == 12, "R4", "period p4 d2", 32'(last_period), 12);
        cfg_prescale = 8'd6; cfg_rate_div = 8'd0; step(4);
        send(16'h0071, 0); wait_idle("R4");
        chk(last_period == 6, "R4", "period p6 d0", 32'(last_period), 6);
        cfg_prescale = 8'd5; cfg_rate_div = 8'd1; step(4);
        send(16'h00E2, 0); wait_idle("R4");
        chk(last_period == 8, "R4", "period p5 d1", 32'(last_period), 8);
        cfg_prescale = 8'd2; cfg_rate_div = 8'd0; step(4);

        // R7: burst framing against single-word framing.
        cfg_block = 1; step(2);
        f0 = frames;
        send(16'h0011, 0); send(16'h0022, 0); send(16'h0033, 1);
        wait_idle("R7");
        chk(frames - f0 == 1, "R7", "frames in burst", 32'(frames - f0), 1);
        f0 = frames;
        send(16'h0044, 0); send(16'h0055, 0);
        w0 = 0;
        while (exp_tx.size() != 0 && w0 < 2000) begin step(1); w0++; end
        step(30);
        chk(cs_n[2] == 0, "R7", "frame held open on empty FIFO", 32'(cs_n[2]), 0);
        send(16'h0066, 1);
        wait_idle("R7");
        chk(frames - f0 == 1, "R7", "open burst frames", 32'(frames - f0), 1);
        chk(cs_n == 8'hFF, "R7", "release after stop word", 32'(cs_n), 32'hFF);
        cfg_block = 0; step(2);
        f0 = frames;
        send(16'h0077, 0); send(16'h0088, 1); send(16'h0099, 0);
        wait_idle("R7");
        chk(frames - f0 == 3, "R7", "frames without burst", 32'(frames - f0), 3);

        // R8: pause holds queued words.
        cfg_pause = 1; step(2);
        e0 = edges;
        send(16'h0012, 0); send(16'h0034, 0); send(16'h0056, 0);
        step(80);
        chk(edges == e0, "R8", "edges while paused", 32'(edges), 32'(e0));
        chk(st_tx_empty == 0, "R8", "words held while paused", 32'(st_tx_empty), 0);
        cfg_pause = 0;
        wait_idle("R8");

        // R6: suppressed selects.
        cfg_cs_off = 1; step(2);
        f0 = frames;
        send(16'h00F0, 0);
        wait_idle("R6");
        chk(frames == f0, "R6", "no frame with selects off", 32'(frames - f0), 0);
        cfg_cs_off = 0; cfg_cs_sel = 3'd7; step(2);
        send(16'h000F, 0);
        wait_idle("R6");

        // R9: receive from miso when loopback is off.
        cfg_loop = 0; miso = 1; step(2);
        send(16'h0000, 0); wait_idle("R9");
        miso = 0; step(2);
        send(16'h00FF, 0); wait_idle("R9");
        cfg_loop = 1; step(2);

        // R1: full transmit FIFO drops the extra push.
        cfg_enable = 0; step(2);
        w0 = words_seen;
        for (int i = 0; i < 16; i++) send(16'(i + 16'h40), 0);
        chk(st_tx_not_full == 0, "R1", "full flag at 16", 32'(st_tx_not_full), 0);
        push(16'h00EE, 0);
        cfg_enable = 1;
        wait_idle("R1");
        chk(words_seen - w0 == 16, "R1", "words sent after overfill", 32'(words_seen - w0), 16);

        // R10: one received word per transfer, then overrun.
        auto_drain = 0; step(2);
        w0 = rx_seen;
        cfg_enable = 0; step(2);
        for (int i = 0; i < 16; i++) send(16'(i + 16'h60), 0);
        cfg_enable = 1;
        wait_idle("R10");
        chk(st_rx_not_empty == 1, "R10", "rx holds words", 32'(st_rx_not_empty), 1);
        chk(st_rx_overrun == 0, "R10", "no overrun at 16", 32'(st_rx_overrun), 0);
        send(16'h00AB, 0);
        wait_idle("R10");
        chk(st_rx_overrun == 1, "R10", "overrun on 17th word", 32'(st_rx_overrun), 1);
        chk(rx_word == 16'h0060, "R10", "oldest word kept", 32'(rx_word), 32'h60);
        chk(rx_seen == w0, "R10", "no pops while draining off", 32'(rx_seen), 32'(w0));
        // R11: receive clear.
        strobe_rx_clear();
        chk(st_rx_not_empty == 0, "R11", "rx empty after clear", 32'(st_rx_not_empty), 0);
        chk(st_rx_overrun == 0, "R11", "overrun cleared", 32'(st_rx_overrun), 0);
        auto_drain = 1; step(2);
        w0 = rx_seen;
        send(16'h00C1, 0); send(16'h00C2, 0);
        wait_idle("R10");
        chk(rx_seen - w0 == 2, "R10", "one rx word per word", 32'(rx_seen - w0), 2);

        finish_run();
    end
endmodule